// File: doc/BRIEF.md
# CPU Power-State Controller

This block sequences the processor between three power states: running, idle and power-down. Software requests a state change with one-cycle request pulses taken from a control register. In idle, the block stops the CPU clock and leaves the peripheral clock and the oscillator running, so any enabled interrupt can bring the CPU back. In power-down, it gates both clocks and drops the oscillator enable. Only two things end power-down: a hardware reset, or an external interrupt line that is enabled and set to level mode.

Leaving power-down through the interrupt line has two phases. A low level turns the oscillator back on. The block then counts a programmable number of stabilisation cycles with the CPU clock still stopped. The exit finishes when the line has gone back high. A hardware reset that arrives during idle does not act at once. The CPU keeps running for a fixed window with RAM writes blocked, and only then is the register-reinitialising reset applied. A power-off flag is set by power-on reset and can be written by software. A warm hardware reset leaves it unchanged, so software can tell a cold start from a warm one.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), the block is in run: CPU clock enable, peripheral clock enable and oscillator enable are 1, the power-off flag is 1, and the wake pulse, RAM-write block and core reset are 0.
- R2: An idle request in run gives, from the next cycle on, CPU clock enable 0 with peripheral clock enable and oscillator enable still 1.
- R3: In idle, a pending enabled interrupt returns the block to run on the next cycle. The wake output is 1 for exactly that first run cycle.
- R4: A power-down request in run sets all three enables to 0 from the next cycle. It wins over an idle request in the same cycle.
- R5: In power-down, the oscillator enable stays 0 under pending interrupts or a low external line unless the line is enabled and in level mode (both `xint_en_i` and `xint_lvl_i` are 1) or a hardware reset is present.
- R6: A qualifying low external line in power-down raises the oscillator enable on the next cycle, with both clocks still gated, for `stab_cnt_i`+1 cycles (value taken on entry). After that, run is entered, with a one-cycle wake pulse, once the line is high.
- R7: A hardware reset in run, or at the end of power-down stabilisation (reset seen at any point during the power-down exit), asserts the core reset with both clocks enabled until `hw_rst_i` falls. Run follows on the next cycle.
- R8: A hardware reset in idle gives exactly `BLK_CYC` cycles with CPU clock enable 1, RAM-write block 1 and core reset 0, then core reset as in R7.
- R9: The power-off flag takes `pof_wdata_i` on the cycle after `pof_wr_i`, holds otherwise, and is not changed by a hardware reset.
- R10: Idle and power-down requests outside run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| hw_rst_i | input | 1 | Hardware reset pin level, active high |
| idle_req_i | input | 1 | Software idle request pulse |
| pd_req_i | input | 1 | Software power-down request pulse |
| irq_pend_i | input | 1 | Any enabled interrupt pending |
| xint_n_i | input | 1 | External wake interrupt line, active low |
| xint_en_i | input | 1 | External wake interrupt enabled |
| xint_lvl_i | input | 1 | External wake interrupt in level mode |
| stab_cnt_i | input | CNT_W | Oscillator stabilisation count |
| pof_wr_i | input | 1 | Power-off flag write strobe |
| pof_wdata_i | input | 1 | Power-off flag write value |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| wake_o | output | 1 | One-cycle interrupt wake event |
| ram_wr_block_o | output | 1 | Internal RAM write inhibit |
| core_rst_o | output | 1 | Special-register reinitialise request |
| pof_o | output | 1 | Power-off flag |

## Verification
The hardest cases to reach are the overlaps inside the power-down exit. One is a hardware reset that arrives part-way through stabilisation. Another is the external line going high before the count has run out, so that the wait-for-high phase passes with no delay. A third is a reset that lands in idle and is dropped during the RAM-block window. Directed sequences set up each of these with small stabilisation counts. Long random runs then hold the reset pin for random lengths while toggling the wake line and the request pulses, and a cycle-level model predicts every output.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_RUN       = 3'd0,
    PS_IDLE      = 3'd1,
    PS_PD_OFF    = 3'd2,
    PS_PD_STAB   = 3'd3,
    PS_PD_WAITHI = 3'd4,
    PS_IDLE_RST  = 3'd5,
    PS_RST_HOLD  = 3'd6
  } pwr_state_e;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pwr_dncnt.sv
module pwr_dncnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (dec_i & (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R6
  cnt_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/pwr_pof.sv
module pwr_pof (
  input  logic clk,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  output logic pof_o
);
  logic pof_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   pof_q <= 1'b1;
    else if (wr_i) pof_q <= wdata_i;
  end

  assign pof_o = pof_q;

  // R9
  pof_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_i |=> $stable(pof_o));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BLK_CYC = 24
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             hw_rst_i,
  input  logic             idle_req_i,
  input  logic             pd_req_i,
  input  logic             irq_pend_i,
  input  logic             xint_n_i,
  input  logic             xint_en_i,
  input  logic             xint_lvl_i,
  input  logic [CNT_W-1:0] stab_cnt_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             cnt_dec_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_en_o,
  output logic             wake_o,
  output logic             ram_wr_block_o,
  output logic             core_rst_o
);
  localparam logic [CNT_W-1:0] BLK_LD = CNT_W'(BLK_CYC - 1);

  pwr_state_e state_q, state_d;
  logic       rsn_q, rsn_d;
  logic       wake_q, wake_d;
  logic       xint_wake;

  assign xint_wake = xint_en_i & xint_lvl_i & ~xint_n_i;

  always_comb begin
    state_d    = state_q;
    rsn_d      = rsn_q;
    wake_d     = 1'b0;
    cnt_load_o = 1'b0;
    cnt_val_o  = stab_cnt_i;
    cnt_dec_o  = 1'b0;
    unique case (state_q)
      PS_RUN: begin
        if (hw_rst_i)        state_d = PS_RST_HOLD;
        else if (pd_req_i)   state_d = PS_PD_OFF;
        else if (idle_req_i) state_d = PS_IDLE;
      end
      PS_IDLE: begin
        if (hw_rst_i) begin
          state_d    = PS_IDLE_RST;
          cnt_load_o = 1'b1;
          cnt_val_o  = BLK_LD;
        end else if (irq_pend_i) begin
          state_d = PS_RUN;
          wake_d  = 1'b1;
        end
      end
      PS_PD_OFF: begin
        if (hw_rst_i || xint_wake) begin
          state_d    = PS_PD_STAB;
          rsn_d      = hw_rst_i;
          cnt_load_o = 1'b1;
        end
      end
      PS_PD_STAB: begin
        rsn_d     = rsn_q | hw_rst_i;
        cnt_dec_o = 1'b1;
        if (cnt_zero_i) state_d = (rsn_q | hw_rst_i) ? PS_RST_HOLD : PS_PD_WAITHI;
      end
      PS_PD_WAITHI: begin
        if (hw_rst_i) state_d = PS_RST_HOLD;
        else if (xint_n_i) begin
          state_d = PS_RUN;
          wake_d  = 1'b1;
        end
      end
      PS_IDLE_RST: begin
        cnt_dec_o = 1'b1;
        if (cnt_zero_i) state_d = PS_RST_HOLD;
      end
      PS_RST_HOLD: begin
        if (!hw_rst_i) state_d = PS_RUN;
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_RUN;
      rsn_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rsn_q   <= rsn_d;
      wake_q  <= wake_d;
    end
  end

  always_comb begin
    cpu_clk_en_o   = (state_q == PS_RUN) || (state_q == PS_IDLE_RST) || (state_q == PS_RST_HOLD);
    per_clk_en_o   = cpu_clk_en_o || (state_q == PS_IDLE);
    osc_en_o       = (state_q != PS_PD_OFF);
    ram_wr_block_o = (state_q == PS_IDLE_RST);
    core_rst_o     = (state_q == PS_RST_HOLD);
    wake_o         = wake_q;
  end

  // R2
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PS_RUN && !hw_rst_i && !pd_req_i && idle_req_i) |=> (!cpu_clk_en_o && per_clk_en_o && osc_en_o));
  // R3
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  // R4
  pd_prio_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == PS_RUN && !hw_rst_i && pd_req_i) |=> (!osc_en_o && !per_clk_en_o && !cpu_clk_en_o));
  // R6
  osc_restart_gated_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(osc_en_o) |-> (!cpu_clk_en_o && !per_clk_en_o));
  // R8
  blk_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(ram_wr_block_o && core_rst_o));
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl #(
  parameter int CNT_W   = 16,
  parameter int BLK_CYC = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst_i,
  input  logic             idle_req_i,
  input  logic             pd_req_i,
  input  logic             irq_pend_i,
  input  logic             xint_n_i,
  input  logic             xint_en_i,
  input  logic             xint_lvl_i,
  input  logic [CNT_W-1:0] stab_cnt_i,
  input  logic             pof_wr_i,
  input  logic             pof_wdata_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_en_o,
  output logic             wake_o,
  output logic             ram_wr_block_o,
  output logic             core_rst_o,
  output logic             pof_o
);
  logic             rst_sn;
  logic             cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_val;

  pwr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_sn)
  );

  pwr_dncnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_ni     (rst_sn),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

  pwr_pof u_pof (
    .clk     (clk),
    .rst_ni  (rst_sn),
    .wr_i    (pof_wr_i),
    .wdata_i (pof_wdata_i),
    .pof_o   (pof_o)
  );

  pwr_fsm #(.CNT_W(CNT_W), .BLK_CYC(BLK_CYC)) u_fsm (
    .clk            (clk),
    .rst_ni         (rst_sn),
    .hw_rst_i       (hw_rst_i),
    .idle_req_i     (idle_req_i),
    .pd_req_i       (pd_req_i),
    .irq_pend_i     (irq_pend_i),
    .xint_n_i       (xint_n_i),
    .xint_en_i      (xint_en_i),
    .xint_lvl_i     (xint_lvl_i),
    .stab_cnt_i     (stab_cnt_i),
    .cnt_zero_i     (cnt_zero),
    .cnt_load_o     (cnt_load),
    .cnt_val_o      (cnt_val),
    .cnt_dec_o      (cnt_dec),
    .cpu_clk_en_o   (cpu_clk_en_o),
    .per_clk_en_o   (per_clk_en_o),
    .osc_en_o       (osc_en_o),
    .wake_o         (wake_o),
    .ram_wr_block_o (ram_wr_block_o),
    .core_rst_o     (core_rst_o)
  );
endmodule

// File: tb/pwr_state_ctrl_bench.sv
module pwr_state_ctrl_bench;
  localparam int CW  = 16;
  localparam int BLK = 24;
  localparam int M_RUN = 0, M_IDLE = 1, M_OFF = 2, M_STAB = 3, M_WHI = 4, M_IRST = 5, M_HOLD = 6;

  logic clk = 1'b0;
  logic rst_n, hw_rst, idle_req, pd_req, irq_pend, xint_n, xint_en, xint_lvl, pof_wr, pof_wdata;
  logic [CW-1:0] stab_cnt;
  logic cpu_en, per_en, osc_en, wake, ram_blk, core_rst, pof;

  int checks = 0, errors = 0;
  int m_st, m_cnt, m_rsn, m_wake, m_pof;

  always #4 clk = ~clk;

  pwr_state_ctrl #(.CNT_W(CW), .BLK_CYC(BLK)) u_pwr_state_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_rst_i(hw_rst), .idle_req_i(idle_req), .pd_req_i(pd_req),
    .irq_pend_i(irq_pend), .xint_n_i(xint_n), .xint_en_i(xint_en), .xint_lvl_i(xint_lvl),
    .stab_cnt_i(stab_cnt), .pof_wr_i(pof_wr), .pof_wdata_i(pof_wdata),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en), .wake_o(wake),
    .ram_wr_block_o(ram_blk), .core_rst_o(core_rst), .pof_o(pof)
  );

  function automatic logic [5:0] exp_vec(int st, int wk);
    logic c, p;
    c = (st == M_RUN) || (st == M_IRST) || (st == M_HOLD);
    p = c || (st == M_IDLE);
    return {c, p, (st != M_OFF), wk[0], (st == M_IRST), (st == M_HOLD)};
  endfunction

  function automatic string st_tag(int st);
    case (st)
      M_IDLE: return "R2";
      M_OFF:  return "R5";
      M_STAB, M_WHI: return "R6";
      M_IRST: return "R8";
      M_HOLD: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int nst = m_st;
    int nw = 0;
    case (m_st)
      M_RUN:  if (hw_rst) nst = M_HOLD; else if (pd_req) nst = M_OFF; else if (idle_req) nst = M_IDLE;
      M_IDLE: if (hw_rst) begin nst = M_IRST; m_cnt = BLK - 1; end
              else if (irq_pend) begin nst = M_RUN; nw = 1; end
      M_OFF:  if (hw_rst || (xint_en && xint_lvl && !xint_n)) begin
                nst = M_STAB; m_rsn = int'(hw_rst); m_cnt = int'(stab_cnt);
              end
      M_STAB: begin
                if (hw_rst) m_rsn = 1;
                if (m_cnt == 0) nst = m_rsn ? M_HOLD : M_WHI; else m_cnt--;
              end
      M_WHI:  if (hw_rst) nst = M_HOLD; else if (xint_n) begin nst = M_RUN; nw = 1; end
      M_IRST: if (m_cnt == 0) nst = M_HOLD; else m_cnt--;
      default: if (!hw_rst) nst = M_RUN;
    endcase
    if (pof_wr) m_pof = int'(pof_wdata);
    m_st = nst;
    m_wake = nw;
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(st_tag(m_st), {cpu_en, per_en, osc_en, wake, ram_blk, core_rst}, exp_vec(m_st, m_wake));
    chk("R9", {5'b0, pof}, {5'b0, m_pof[0]});
  endtask

  task automatic neutral();
    hw_rst = 0; idle_req = 0; pd_req = 0; irq_pend = 0; pof_wr = 0; pof_wdata = 0;
    xint_n = 1; xint_en = 1; xint_lvl = 1;
  endtask

  task automatic por();
    rst_n = 0; neutral();
    m_st = M_RUN; m_wake = 0; m_pof = 1; m_cnt = 0; m_rsn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    stab_cnt = 16'd3;
    por();
    // R1 reset state
    chk("R1", {cpu_en, per_en, osc_en, wake, ram_blk, core_rst, pof}, 7'b1110001);
    // R2 / R3 idle and wake
    idle_req = 1; step(); idle_req = 0; step();
    irq_pend = 1; step(); irq_pend = 0; step();
    // R4 power-down beats idle
    pd_req = 1; idle_req = 1; step(); pd_req = 0; idle_req = 0;
    chk("R4", {cpu_en, per_en, osc_en, 3'b0}, 6'b0);
    // R5 no wake from irq or edge-mode line
    irq_pend = 1; step(); step(); irq_pend = 0;
    xint_n = 0; xint_lvl = 0; step(); step();
    xint_en = 0; xint_lvl = 1; step();
    chk("R5", {2'b0, osc_en, 3'b0}, 6'b0);
    // R6 level wake, line back high early during stabilisation
    xint_en = 1; step(); step(); xint_n = 1;
    repeat (5) step();
    // R6 line held low past stabilisation, release later
    pd_req = 1; step(); pd_req = 0; stab_cnt = 16'd0;
    xint_n = 0; repeat (4) step(); xint_n = 1; repeat (2) step();
    // R10 request ignored in idle
    idle_req = 1; step(); idle_req = 0; pd_req = 1; step(); pd_req = 0;
    chk("R10", {2'b0, osc_en, 3'b0}, 6'b001000);
    // R8 reset in idle, dropped inside the window
    hw_rst = 1; repeat (3) step(); hw_rst = 0; repeat (BLK + 2) step();
    // R9 software write, survives hardware reset
    pof_wr = 1; pof_wdata = 0; step(); pof_wr = 0;
    // R7 reset in run
    hw_rst = 1; repeat (3) step(); hw_rst = 0; step();
    chk("R9", {5'b0, pof}, 6'b0);
    // R7 reset arrives mid-stabilisation after a level wake
    stab_cnt = 16'd5; pd_req = 1; step(); pd_req = 0;
    xint_n = 0; step(); xint_n = 1; step(); step(); hw_rst = 1; step(); hw_rst = 0;
    repeat (6) step();
    // R9 power-on reset sets flag again
    por();
    chk("R9", {5'b0, pof}, 6'b1);

    for (int i = 0; i < 20000; i++) begin
      if (hw_rst) hw_rst = ($urandom_range(0, 3) != 0);
      else        hw_rst = ($urandom_range(0, 79) == 0);
      idle_req  = ($urandom_range(0, 11) == 0);
      pd_req    = ($urandom_range(0, 15) == 0);
      irq_pend  = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 5) == 0) xint_n = ~xint_n;
      xint_en   = ($urandom_range(0, 7) != 0);
      xint_lvl  = ($urandom_range(0, 7) != 0);
      pof_wr    = ($urandom_range(0, 31) == 0);
      pof_wdata = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) stab_cnt = 16'($urandom_range(0, 9));
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule